// File: doc/BRIEF.md
# Secondary Packet Buffer with Slot-Gated Release

This block sits between a user source of secondary-data packets and the main-link inserter. The source presents packet words over a valid/ready handshake with start and end markers. Words are kept in an internal word store, and each stored packet is released whole, on back-to-back cycles, only when the link scheduler raises its slot-available signal. The block never releases a packet on its own initiative.

Backpressure is the only flow control on the input. A packet is admitted only if its first word finds room for a packet of the largest allowed length, so a packet that has started always fits. Once a packet has started, the source must keep valid high on every cycle until the end word. A hole in valid in the middle of a packet is a protocol violation: the partial packet is removed, the rest of it is swallowed, and a sticky error flag is raised.

Top module: `sec_pkt_buf`

## Requirements
- R1: Packets leave in the order they arrived, with every word's data, start flag and end flag unchanged.
- R2: With no packet in progress, in_ready is high only when the free space (64 words minus stored words) is at least 16 words; a start word is taken only then.
- R3: The store never holds more than 64 words; inside a packet in_ready is high exactly while the store is not full.
- R4: Release starts on the cycle after slot_avail is seen high while no release is running and pkt_count is non-zero; out_valid is never high without a stored complete packet.
- R5: A released packet appears on consecutive cycles with out_sop on its first word and out_eop on its last; out_valid is low for at least one cycle after an end word.
- R6: A cycle with in_valid low inside a packet sets proto_err, which stays high until reset; the words of that packet already stored are discarded, and its remaining words up to and including the end word are accepted and dropped.
- R7: pkt_count rises by one for each end word stored, falls by one for each end word released, and changes by at most one per cycle.
- R8: A synchronous reset (rst high) empties the store and clears pkt_count, proto_err and out_valid; in_ready is low during reset and on the first cycle after it.
- R9: An accepted word that does not carry a start flag while no packet is in progress is dropped and changes neither the store nor pkt_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Source word |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| slot_avail | input | 1 | Scheduler grants an insertion slot |
| out_valid | output | 1 | Released word valid |
| out_data | output | 32 | Released word |
| out_sop | output | 1 | First released word of a packet |
| out_eop | output | 1 | Last released word of a packet |
| pkt_count | output | 7 | Complete packets stored |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest state to reach is the admission boundary: the store must be filled to within fewer than sixteen free words while the scheduler withholds slots, and only then can a start word be shown to wait. The stimulus holds slot_avail low while it loads three full-length packets and a ten-word one, offers a further start word for several cycles, then grants a single slot and confirms that admission resumes while a release is running. A mid-packet gap is also forced while an earlier packet is draining, so that rollback of the write side coincides with reads.

// File: rtl/sec_pkt_pkg.sv
package sec_pkt_pkg;

  typedef enum logic [1:0] {
    ING_IDLE = 2'd0,
    ING_PKT  = 2'd1,
    ING_DROP = 2'd2
  } ing_state_t;

  // Free words left given the number of stored words.
  function automatic int unsigned free_words(int unsigned depth, int unsigned used);
    return (used >= depth) ? 0 : depth - used;
  endfunction

  // A new packet may begin only if a full-length one would fit.
  function automatic logic room_for_packet(int unsigned depth, int unsigned used,
                                           int unsigned max_pkt);
    return free_words(depth, used) >= max_pkt;
  endfunction

endpackage

// File: rtl/sec_pkt_store.sv
module sec_pkt_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 34,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              mark_start,
  input  logic              rollback,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic [AW:0]       used
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr, start_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      start_ptr <= '0;
    end else begin
      if (rollback) begin
        wr_ptr <= start_ptr;
      end else if (wr_en) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (mark_start) start_ptr <= wr_ptr;
      end
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_word = mem[rd_ptr[AW-1:0]];
  assign used    = wr_ptr - rd_ptr;

endmodule

// File: rtl/sec_pkt_ingress.sv
module sec_pkt_ingress
  import sec_pkt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic blocked,
  input  logic in_valid,
  input  logic in_sop,
  input  logic in_eop,
  input  logic room_ok,
  input  logic not_full,
  output logic in_ready,
  output logic wr_en,
  output logic mark_start,
  output logic rollback,
  output logic err_pulse,
  output logic eop_stored
);

  ing_state_t state, state_nx;
  logic accept;

  always_comb begin
    unique case (state)
      ING_IDLE: in_ready = room_ok;
      ING_PKT:  in_ready = not_full;
      default:  in_ready = 1'b1;
    endcase
    if (blocked) in_ready = 1'b0;
  end

  assign accept = in_valid && in_ready;

  always_comb begin
    state_nx   = state;
    wr_en      = 1'b0;
    mark_start = 1'b0;
    rollback   = 1'b0;
    err_pulse  = 1'b0;
    eop_stored = 1'b0;
    unique case (state)
      ING_IDLE: if (accept && in_sop) begin
        wr_en      = 1'b1;
        mark_start = 1'b1;
        eop_stored = in_eop;
        if (!in_eop) state_nx = ING_PKT;
      end
      ING_PKT: begin
        if (!in_valid && !blocked) begin
          rollback  = 1'b1;
          err_pulse = 1'b1;
          state_nx  = ING_DROP;
        end else if (accept) begin
          wr_en      = 1'b1;
          eop_stored = in_eop;
          if (in_eop) state_nx = ING_IDLE;
        end
      end
      default: if (accept && in_eop) state_nx = ING_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ING_IDLE;
    else     state <= state_nx;
  end

endmodule

// File: rtl/sec_pkt_egress.sv
module sec_pkt_egress (
  input  logic clk,
  input  logic rst,
  input  logic slot_avail,
  input  logic pkt_stored,
  input  logic head_eop,
  output logic busy,
  output logic eop_released
);

  assign eop_released = busy && head_eop;

  always_ff @(posedge clk) begin
    if (rst)                              busy <= 1'b0;
    else if (busy && head_eop)            busy <= 1'b0;
    else if (!busy && slot_avail && pkt_stored) busy <= 1'b1;
  end

endmodule

// File: rtl/sec_pkt_buf.sv
module sec_pkt_buf
  import sec_pkt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 64,
  parameter int MAX_PKT = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int WORD_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              slot_avail,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [CW-1:0]     pkt_count,
  output logic              proto_err
);

  // Named internal events, observed by the bound checker.
  logic [AW:0]       used;
  logic              room_ok, not_full, hold_q, blocked;
  logic              wr_en, mark_start, rollback, err_pulse, eop_stored;
  logic              busy, eop_released;
  logic [WORD_W-1:0] head_word;

  assign room_ok  = room_for_packet(DEPTH, 32'(used), MAX_PKT);
  assign not_full = 32'(used) < DEPTH;
  assign blocked  = rst || hold_q;

  always_ff @(posedge clk) hold_q <= rst;

  sec_pkt_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) store_i (
    .clk, .rst, .wr_en, .mark_start, .rollback,
    .wr_word ({in_sop, in_eop, in_data}),
    .rd_en   (busy),
    .rd_word (head_word),
    .used
  );

  sec_pkt_ingress ingress_i (
    .clk, .rst, .blocked, .in_valid, .in_sop, .in_eop, .room_ok, .not_full,
    .in_ready, .wr_en, .mark_start, .rollback, .err_pulse, .eop_stored
  );

  sec_pkt_egress egress_i (
    .clk, .rst, .slot_avail,
    .pkt_stored   (pkt_count != '0),
    .head_eop     (head_word[DATA_W]),
    .busy, .eop_released
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_count <= '0;
      proto_err <= 1'b0;
    end else begin
      pkt_count <= pkt_count + CW'(eop_stored) - CW'(eop_released);
      if (err_pulse) proto_err <= 1'b1;
    end
  end

  assign out_valid = busy;
  assign out_data  = head_word[DATA_W-1:0];
  assign out_sop   = busy && head_word[DATA_W+1];
  assign out_eop   = busy && head_word[DATA_W];

endmodule

// File: rtl/sec_pkt_buf_chk.sv
module sec_pkt_buf_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          slot_avail,
  input logic          out_valid,
  input logic          out_sop,
  input logic          out_eop,
  input logic [CW-1:0] pkt_count,
  input logic          proto_err,
  input logic [AW:0]   used
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    32'(used) <= DEPTH);

  assert_slot_gate_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(slot_avail));

  assert_drain_needs_packet_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pkt_count != '0);

  assert_starts_sop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sop);

  assert_contiguous_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eop |=> out_valid);

  assert_idle_after_eop_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eop |=> !out_valid);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pkt_count == $past(pkt_count)
                     || pkt_count == $past(pkt_count) + 1'b1
                     || pkt_count == $past(pkt_count) - 1'b1));

  assert_ready_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !in_ready);

endmodule

bind sec_pkt_buf sec_pkt_buf_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
  .clk, .rst, .in_ready, .slot_avail, .out_valid, .out_sop, .out_eop,
  .pkt_count, .proto_err, .used
);

// File: tb/sec_pkt_buf_tb_top.sv
module sec_pkt_buf_tb_top;

  localparam int DEPTH = 64;
  localparam int MAXP  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, slot_avail = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop, proto_err;
  logic [31:0] out_data;
  logic [6:0]  pkt_count;

  always #5 clk = ~clk;

  sec_pkt_buf dut_i (
    .clk, .rst, .in_valid, .in_ready, .in_data, .in_sop, .in_eop,
    .slot_avail, .out_valid, .out_data, .out_sop, .out_eop,
    .pkt_count, .proto_err
  );

  int checks = 0, errors = 0;

  // Behavioural reference: queue of {sop, eop, data}
  logic [33:0] q[$];
  int  m_state = 0;   // 0 idle, 1 in packet, 2 dropping
  int  m_part  = 0;
  int  m_count = 0;
  bit  m_busy  = 0, m_err = 0, m_hold = 1;
  bit  accepted;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_ready();
    if (rst || m_hold) return 0;
    if (m_state == 0) return (DEPTH - q.size()) >= MAXP;
    if (m_state == 1) return q.size() < DEPTH;
    return 1;
  endfunction

  task automatic step(bit v, bit s, bit e, logic [31:0] d, bit sl);
    bit rdy, start_rd, eop_in, eop_out;
    in_valid = v; in_sop = s; in_eop = e; in_data = d; slot_avail = sl;
    #1;
    rdy = model_ready();
    if (!rst) begin
      check("R2/R3 in_ready", in_ready, rdy);
      check("R4/R5 out_valid", out_valid, m_busy);
      if (m_busy) begin
        check("R1 out_data", out_data, q[0][31:0]);
        check("R5 out_sop", out_sop, q[0][33]);
        check("R5 out_eop", out_eop, q[0][32]);
      end
      check("R7 pkt_count", pkt_count, m_count);
      check("R6 proto_err", proto_err, m_err);
    end
    accepted = v && rdy;
    if (rst) begin
      q.delete(); m_state = 0; m_part = 0; m_count = 0;
      m_busy = 0; m_err = 0; m_hold = 1;
    end else begin
      m_hold = 0;
      eop_out = 0; start_rd = 0; eop_in = 0;
      if (m_busy) begin
        eop_out = q[0][32];
        void'(q.pop_front());
      end else if (sl && m_count > 0) start_rd = 1;
      case (m_state)
        0: if (accepted && s) begin
             q.push_back({s, e, d});
             if (e) eop_in = 1; else begin m_state = 1; m_part = 1; end
           end
        1: if (!v) begin
             m_err = 1;
             for (int k = 0; k < m_part; k++) void'(q.pop_back());
             m_part = 0; m_state = 2;
           end else if (accepted) begin
             q.push_back({s, e, d}); m_part++;
             if (e) begin eop_in = 1; m_state = 0; m_part = 0; end
           end
        default: if (accepted && e) m_state = 0;
      endcase
      if (eop_out) m_busy = 0;
      if (start_rd) m_busy = 1;
      m_count = m_count + int'(eop_in) - int'(eop_out);
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(int n, bit sl);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, sl);
  endtask

  task automatic send_pkt(int len, logic [31:0] base, int gap_at, bit sl);
    int i = 0;
    bit gapped = 0;
    while (i < len) begin
      if (i == gap_at && !gapped) begin
        step(0, 0, 0, '0, sl);
        gapped = 1;
      end else begin
        step(1, i == 0, i == len - 1, base + 32'(i), sl);
        if (accepted) i++;
      end
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; idle(3, 0);
    rst = 0;
    // R8: ready low on the first cycle after reset, everything cleared
    #1;
    check("R8 ready after reset", in_ready, 0);
    check("R8 out_valid after reset", out_valid, 0);
    check("R8 count after reset", pkt_count, 0);
    check("R8 err after reset", proto_err, 0);
    idle(1, 0);

    // R1/R4: single-word packet with slot open
    send_pkt(1, 32'hA000, -1, 1);
    idle(4, 1);

    // R4: packets wait while slot is low
    send_pkt(5, 32'hB000, -1, 0);
    send_pkt(16, 32'hC000, -1, 0);
    idle(6, 0);
    check("R4 count held", pkt_count, 2);
    idle(30, 1);

    // R2: fill to 58 words with slot low, start word must wait
    for (int p = 0; p < 3; p++) send_pkt(16, 32'h1000 * (p + 1), -1, 0);
    send_pkt(10, 32'h5000, -1, 0);
    for (int i = 0; i < 5; i++) begin
      step(1, 1, 0, 32'hD000, 0);
      check("R2 start word blocked", accepted, 0);
    end
    step(0, 0, 0, '0, 1);           // one slot grant
    send_pkt(8, 32'hE000, -1, 0);   // admitted once release frees room
    idle(120, 1);

    // R6: gap mid-packet during a release
    send_pkt(4, 32'h6000, -1, 0);
    send_pkt(6, 32'h7000, 3, 1);
    check("R6 err set", proto_err, 1);
    send_pkt(3, 32'h8000, -1, 1);
    idle(20, 1);
    check("R6 err sticky", proto_err, 1);

    // R9: stray word with no start flag while idle
    step(1, 0, 1, 32'h9999, 0);
    idle(2, 0);
    check("R9 stray dropped", pkt_count, 0);
    idle(4, 1);

    // R1/R7: mixed lengths with slot toggling
    for (int k = 0; k < 20; k++) send_pkt(((k * 7) % MAXP) + 1, 32'h10000 * k, -1, k[0]);
    idle(200, 1);

    // R8: reset with packets stored
    send_pkt(5, 32'hF000, -1, 0);
    rst = 1; idle(2, 0);
    rst = 0; idle(10, 1);
    check("R8 empty after reset", pkt_count, 0);
    check("R8 err cleared", proto_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule